// File: doc/BRIEF.md
# Delayed Write Retry Controller

This block sits inside a bus bridge and owns the retry loop for a single delayed write. When the initiator side hands over a queued write, the controller launches an attempt on the target bus and waits for the outcome, which arrives as a strobe carrying a termination code. A target retry causes another launch. A normal completion, a disconnect after data, a target abort or a master abort ends the loop. The result is then kept until the initiator repeats its write, and that repeat receives the stored code.

Retries ending in target retry are counted. A configuration input selects either a short limit of 2^DEF_LOG2 attempts or a long limit of 2^MAX_LOG2 attempts. When the count reaches the selected limit, the request is thrown away and no further attempts are made. The controller pulses a system error line, unless the non-delivery mask is set. It also sets a sticky status flag that stays set until software clears it. The initiator's next repeat of the write is then answered with a target abort.

Top module: `dw_retry_ctrl`

## Requirements
- R1: After reset, busy, tgt_start, resp_valid, serr_pulse and nodeliver_flag are all 0.
- R2: A req_valid sampled while idle gives tgt_start high for exactly one cycle, starting on the next clock. busy is high from that edge until the initiator collects the outcome.
- R3: Termination codes on tgt_term and resp_code are: 0 normal, 1 target retry, 2 disconnect, 3 target abort, 4 master abort. A tgt_done carrying code 1 below the limit gives a new tgt_start pulse on the next clock.
- R4: A tgt_done carrying code 0, 2, 3 or 4 ends the loop. No further tgt_start occurs for that request.
- R5: With cfg_long_limit=0, the request is dropped after exactly 2^DEF_LOG2 retry terminations. With cfg_long_limit=1, it is dropped after exactly 2^MAX_LOG2. In both cases the final retry causes no new tgt_start.
- R6: On the retry that exhausts the limit, serr_pulse is high for exactly one cycle on the next clock if serr_mask_nodeliver is 0. It stays low if the mask is 1.
- R7: nodeliver_flag is set on exhaustion whatever the mask setting. It holds until a cycle with nodeliver_clr high.
- R8: An init_retry sampled while an attempt is still outstanding gives resp_valid for one cycle on the next clock, with resp_code 1.
- R9: After a loop ends through R4, an init_retry gives resp_valid with resp_code equal to the received termination code, and busy returns to 0.
- R10: After a drop through R5, an init_retry gives resp_valid with resp_code 3, and busy returns to 0.
- R11: The retry count restarts at zero for every accepted request, so each new request gets the full limit.
- R12: req_valid has no effect while busy is 1. No tgt_start is produced by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_long_limit | input | 1 | 0 selects the short retry limit, 1 selects the long limit |
| serr_mask_nodeliver | input | 1 | Suppresses serr_pulse on non-delivery |
| nodeliver_clr | input | 1 | Software clear of the sticky non-delivery flag |
| req_valid | input | 1 | New delayed write request from the initiator side |
| init_retry | input | 1 | Initiator repeats its delayed write |
| tgt_done | input | 1 | Strobe: the current target-bus attempt has terminated |
| tgt_term | input | 3 | Termination code that goes with tgt_done |
| busy | output | 1 | A request is held |
| tgt_start | output | 1 | One-cycle launch of an attempt on the target bus |
| resp_valid | output | 1 | One-cycle answer to init_retry |
| resp_code | output | 3 | Termination code returned to the initiator |
| serr_pulse | output | 1 | One-cycle system error indication on non-delivery |
| nodeliver_flag | output | 1 | Sticky non-delivery status |

## Verification
The assertions check, on every cycle, the one-cycle width of tgt_start and serr_pulse and that the sticky flag follows any error pulse. They also check that the counter never steps past the selected limit and that a finishing termination is never followed by a launch. They cover the answers given to an initiator repeat while the request is pending and after a drop. Only the bench scenarios can show the exact number of attempts before a drop under each limit setting, and that the count restarts with a new request. The same holds for the masked exhaustion path and the pass-back of each of the four ending codes.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  typedef enum logic [2:0] {
    TERM_NORMAL     = 3'd0,
    TERM_RETRY      = 3'd1,
    TERM_DISCONNECT = 3'd2,
    TERM_TABORT     = 3'd3,
    TERM_MABORT     = 3'd4
  } term_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LAUNCH  = 3'd1,
    ST_AWAIT   = 3'd2,
    ST_HOLD    = 3'd3,
    ST_DROPPED = 3'd4
  } state_e;

  function automatic logic is_retry(input logic [2:0] code);
    return code == TERM_RETRY;
  endfunction
endpackage

// File: rtl/dwr_attempt_cnt.sv
module dwr_attempt_cnt #(
  parameter int DEF_LOG2 = 24,
  parameter int MAX_LOG2 = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic long_sel,
  input  logic clr,
  input  logic inc,
  output logic last_one
);
  localparam int CNT_W = MAX_LOG2 + 1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] LIM_DEF = ONE << DEF_LOG2;
  localparam logic [CNT_W-1:0] LIM_MAX = ONE << MAX_LOG2;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;

  assign limit    = long_sel ? LIM_MAX : LIM_DEF;
  assign last_one = (count + ONE) == limit;

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + ONE;
  end

  // R5
  cnt_within_limit_chk: assert property (@(posedge clk) disable iff (rst)
    inc |-> (count < limit));

  // R11
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
endmodule

// File: rtl/dwr_err_report.sv
module dwr_err_report (
  input  logic clk,
  input  logic rst,
  input  logic exhaust,
  input  logic mask,
  input  logic clr,
  output logic serr_pulse,
  output logic sticky
);
  always_ff @(posedge clk) begin
    if (rst) begin
      serr_pulse <= 1'b0;
      sticky     <= 1'b0;
    end else begin
      serr_pulse <= exhaust && !mask;
      if (exhaust)  sticky <= 1'b1;
      else if (clr) sticky <= 1'b0;
    end
  end

  // R6
  serr_single_chk: assert property (@(posedge clk) disable iff (rst)
    serr_pulse |=> !serr_pulse);

  // R7
  sticky_follows_serr_chk: assert property (@(posedge clk) disable iff (rst)
    serr_pulse |-> sticky);
endmodule

// File: rtl/dwr_sequencer.sv
module dwr_sequencer
  import dwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       init_retry,
  input  logic       tgt_done,
  input  logic [2:0] tgt_term,
  input  logic       last_one,
  output logic       cnt_clr,
  output logic       cnt_inc,
  output logic       exhaust,
  output logic       busy,
  output logic       tgt_start,
  output logic       resp_valid,
  output logic [2:0] resp_code
);
  state_e     state;
  logic [2:0] held;
  logic       retry_seen;
  logic [2:0] final_code;

  assign retry_seen = (state == ST_AWAIT) && tgt_done && is_retry(tgt_term);
  assign cnt_clr    = (state == ST_IDLE) && req_valid;
  assign cnt_inc    = retry_seen;
  assign exhaust    = retry_seen && last_one;
  assign busy       = (state != ST_IDLE);
  assign final_code = (tgt_term > TERM_MABORT) ? TERM_TABORT : tgt_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      held       <= TERM_NORMAL;
      tgt_start  <= 1'b0;
      resp_valid <= 1'b0;
      resp_code  <= TERM_NORMAL;
    end else begin
      tgt_start  <= 1'b0;
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state     <= ST_LAUNCH;
            tgt_start <= 1'b1;
          end
        end
        ST_LAUNCH: begin
          state <= ST_AWAIT;
          if (init_retry) begin
            resp_valid <= 1'b1;
            resp_code  <= TERM_RETRY;
          end
        end
        ST_AWAIT: begin
          if (init_retry) begin
            resp_valid <= 1'b1;
            resp_code  <= TERM_RETRY;
          end
          if (tgt_done) begin
            if (is_retry(tgt_term)) begin
              if (last_one) begin
                state <= ST_DROPPED;
              end else begin
                state     <= ST_LAUNCH;
                tgt_start <= 1'b1;
              end
            end else begin
              held  <= final_code;
              state <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (init_retry) begin
            resp_valid <= 1'b1;
            resp_code  <= held;
            state      <= ST_IDLE;
          end
        end
        ST_DROPPED: begin
          if (init_retry) begin
            resp_valid <= 1'b1;
            resp_code  <= TERM_TABORT;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_start |=> !tgt_start);

  // R4
  finish_no_launch_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_AWAIT) && tgt_done && !is_retry(tgt_term)) |=> !tgt_start);

  // R8
  pending_answer_chk: assert property (@(posedge clk) disable iff (rst)
    (init_retry && ((state == ST_LAUNCH) || (state == ST_AWAIT)))
      |=> (resp_valid && resp_code == TERM_RETRY));

  // R10
  dropped_answer_chk: assert property (@(posedge clk) disable iff (rst)
    (init_retry && (state == ST_DROPPED))
      |=> (resp_valid && resp_code == TERM_TABORT && !busy));

  // R12
  busy_ignores_req_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !retry_seen) |=> !tgt_start);
endmodule

// File: rtl/dw_retry_ctrl.sv
module dw_retry_ctrl #(
  parameter int DEF_LOG2 = 24,
  parameter int MAX_LOG2 = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_long_limit,
  input  logic       serr_mask_nodeliver,
  input  logic       nodeliver_clr,
  input  logic       req_valid,
  input  logic       init_retry,
  input  logic       tgt_done,
  input  logic [2:0] tgt_term,
  output logic       busy,
  output logic       tgt_start,
  output logic       resp_valid,
  output logic [2:0] resp_code,
  output logic       serr_pulse,
  output logic       nodeliver_flag
);
  logic cnt_clr, cnt_inc, last_one, exhaust;

  dwr_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .init_retry (init_retry),
    .tgt_done   (tgt_done),
    .tgt_term   (tgt_term),
    .last_one   (last_one),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .exhaust    (exhaust),
    .busy       (busy),
    .tgt_start  (tgt_start),
    .resp_valid (resp_valid),
    .resp_code  (resp_code)
  );

  dwr_attempt_cnt #(
    .DEF_LOG2 (DEF_LOG2),
    .MAX_LOG2 (MAX_LOG2)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .long_sel (cfg_long_limit),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .last_one (last_one)
  );

  dwr_err_report u_err (
    .clk        (clk),
    .rst        (rst),
    .exhaust    (exhaust),
    .mask       (serr_mask_nodeliver),
    .clr        (nodeliver_clr),
    .serr_pulse (serr_pulse),
    .sticky     (nodeliver_flag)
  );
endmodule

// File: tb/dw_retry_ctrl_test.sv
module dw_retry_ctrl_test;
  localparam int DEF_LOG2 = 3;
  localparam int MAX_LOG2 = 4;
  localparam int LIM_S = 1 << DEF_LOG2;
  localparam int LIM_L = 1 << MAX_LOG2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_long_limit = 1'b0, serr_mask_nodeliver = 1'b0, nodeliver_clr = 1'b0;
  logic req_valid = 1'b0, init_retry = 1'b0, tgt_done = 1'b0;
  logic [2:0] tgt_term = 3'd0;
  logic busy, tgt_start, resp_valid, serr_pulse, nodeliver_flag;
  logic [2:0] resp_code;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dw_retry_ctrl #(.DEF_LOG2(DEF_LOG2), .MAX_LOG2(MAX_LOG2)) uut (
    .clk(clk), .rst(rst), .cfg_long_limit(cfg_long_limit),
    .serr_mask_nodeliver(serr_mask_nodeliver), .nodeliver_clr(nodeliver_clr),
    .req_valid(req_valid), .init_retry(init_retry), .tgt_done(tgt_done),
    .tgt_term(tgt_term), .busy(busy), .tgt_start(tgt_start),
    .resp_valid(resp_valid), .resp_code(resp_code),
    .serr_pulse(serr_pulse), .nodeliver_flag(nodeliver_flag)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic issue_req();
    @(negedge clk); req_valid = 1'b1;
    tick();
    check(tgt_start == 1'b1, "R2 launch", tgt_start, 1);
    check(busy == 1'b1, "R2 busy", busy, 1);
    @(negedge clk); req_valid = 1'b0;
    tick();
    check(tgt_start == 1'b0, "R2 single pulse", tgt_start, 0);
  endtask

  task automatic terminate(input logic [2:0] code, output logic start_seen,
                           output logic serr_seen);
    @(negedge clk); tgt_done = 1'b1; tgt_term = code;
    tick();
    start_seen = tgt_start;
    serr_seen  = serr_pulse;
    @(negedge clk); tgt_done = 1'b0;
    tick();
  endtask

  task automatic init_repeat(input logic [2:0] exp, input string req);
    @(negedge clk); init_retry = 1'b1;
    tick();
    check(resp_valid == 1'b1, req, resp_valid, 1);
    check(resp_code == exp, req, resp_code, exp);
    @(negedge clk); init_retry = 1'b0;
    tick();
    check(resp_valid == 1'b0, req, resp_valid, 0);
  endtask

  task automatic t_reset();
    check(busy == 0 && tgt_start == 0 && resp_valid == 0, "R1 ctrl", busy, 0);
    check(serr_pulse == 0 && nodeliver_flag == 0, "R1 err", serr_pulse, 0);
  endtask

  task automatic t_finish(input logic [2:0] code, input string req);
    logic s, e;
    issue_req();
    terminate(3'd1, s, e);
    check(s == 1'b1, "R3 retry relaunch", s, 1);
    terminate(code, s, e);
    check(s == 1'b0, "R4 no launch after finish", s, 0);
    repeat (3) begin
      tick();
      check(tgt_start == 1'b0, "R4 quiet", tgt_start, 0);
    end
    init_repeat(code, req);
    check(busy == 1'b0, "R9 idle after answer", busy, 0);
  endtask

  task automatic t_pending_answer();
    logic s, e;
    issue_req();
    init_repeat(3'd1, "R8 pending answer");
    terminate(3'd0, s, e);
    init_repeat(3'd0, "R9 normal pass-back");
  endtask

  task automatic t_busy_ignore();
    logic s, e;
    issue_req();
    @(negedge clk); req_valid = 1'b1;
    repeat (3) begin
      tick();
      check(tgt_start == 1'b0, "R12 req ignored while busy", tgt_start, 0);
    end
    @(negedge clk); req_valid = 1'b0;
    terminate(3'd2, s, e);
    @(negedge clk); req_valid = 1'b1;
    tick();
    check(tgt_start == 1'b0, "R12 req ignored in hold", tgt_start, 0);
    @(negedge clk); req_valid = 1'b0;
    init_repeat(3'd2, "R9 disconnect pass-back");
  endtask

  task automatic t_exhaust(input logic long_sel, input logic mask, input int lim);
    logic s, e;
    cfg_long_limit = long_sel;
    serr_mask_nodeliver = mask;
    issue_req();
    for (int i = 1; i < lim; i++) begin
      terminate(3'd1, s, e);
      check(s == 1'b1, "R5 relaunch below limit", s, 1);
      check(e == 1'b0, "R6 no early serr", e, 0);
    end
    terminate(3'd1, s, e);
    check(s == 1'b0, "R5 no launch at limit", s, 0);
    check(e == !mask, "R6 serr at limit", e, !mask);
    check(serr_pulse == 1'b0, "R6 serr one cycle", serr_pulse, 0);
    check(nodeliver_flag == 1'b1, "R7 sticky set", nodeliver_flag, 1);
    repeat (2) begin
      tick();
      check(tgt_start == 1'b0, "R5 stopped", tgt_start, 0);
    end
    init_repeat(3'd3, "R10 abort after drop");
    check(busy == 1'b0, "R10 idle", busy, 0);
    check(nodeliver_flag == 1'b1, "R7 sticky holds", nodeliver_flag, 1);
    @(negedge clk); nodeliver_clr = 1'b1;
    tick();
    check(nodeliver_flag == 1'b0, "R7 sticky cleared", nodeliver_flag, 0);
    @(negedge clk); nodeliver_clr = 1'b0;
    cfg_long_limit = 1'b0;
    serr_mask_nodeliver = 1'b0;
  endtask

  task automatic t_restart();
    logic s, e;
    issue_req();
    repeat (3) terminate(3'd1, s, e);
    terminate(3'd0, s, e);
    init_repeat(3'd0, "R11 first finish");
    issue_req();
    for (int i = 1; i < LIM_S; i++) begin
      terminate(3'd1, s, e);
      check(s == 1'b1, "R11 full count after restart", s, 1);
    end
    terminate(3'd1, s, e);
    check(s == 1'b0 && e == 1'b1, "R11 drop at full limit", s, 0);
    tick();
    init_repeat(3'd3, "R11 abort after drop");
    @(negedge clk); nodeliver_clr = 1'b1;
    @(negedge clk); nodeliver_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    tick();
    t_reset();
    t_finish(3'd0, "R9 normal");
    t_finish(3'd2, "R9 disconnect");
    t_finish(3'd3, "R9 target abort");
    t_finish(3'd4, "R9 master abort");
    t_pending_answer();
    t_busy_ignore();
    t_exhaust(1'b0, 1'b0, LIM_S);
    t_exhaust(1'b1, 1'b1, LIM_L);
    t_exhaust(1'b1, 1'b0, LIM_L);
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule